// File: doc/BRIEF.md
# Pipelined CORDIC Vector Rotator with Gain Compensation

The block rotates a two-component fixed-point vector through a sequence of eight micro-rotations, then multiplies both components by a gain-compensation constant near 0.6073. Every micro-rotation and every compensation step has its own register stage. The pipeline is therefore fourteen stages deep and accepts a new vector on every clock. The caller chooses the direction of each micro-rotation with one direction bit per iteration and with a global mode bit. The mode bit and the direction bits travel down the pipeline together with their vector, so the caller can change them on every cycle.

The 8-bit two's-complement inputs are widened to a 12-bit internal format that has two fractional guard bits. Each stage uses only a shift and a ripple add or subtract. The result is rounded back to 8 bits and clamped to the signed 8-bit range. A valid flag moves alongside the data. A synchronous reset clears every valid flag in the pipeline.

Top module: `cordic_rot_pipe`

## Requirements
- R1: While reset is high, every stage's valid flag is cleared at each rising edge. Vectors that are in flight when reset is asserted never appear at the output, and out_valid is low in the cycle after reset falls.
- R2: The result for a vector sampled with in_valid high at rising edge n is presented, with out_valid high, after rising edge n+13. A vector may enter on every edge, results leave in entry order, and out_valid is never high without a matching input.
- R3: Each 8-bit two's-complement input is sign-extended to 12 bits and multiplied by 4, so the internal word has 2 fractional bits.
- R4: Iteration i (0 to 7) uses direction bit in_dir[i]. If in_mode XOR in_dir[i] is 0, the stage computes X' = X + (Y>>>i) and Y' = Y - (X>>>i). If it is 1, the stage computes X' = X - (Y>>>i) and Y' = Y + (X>>>i).
- R5: Every shift inside the datapath is an arithmetic right shift, which rounds toward minus infinity.
- R6: After the rotations, six stages apply V' = V - (V>>>s) with s equal to 2, 3, 4 and 6 in that order, and then V' = V + (V>>>s) with s equal to 9 and 11. Both components go through these steps.
- R7: The 12-bit result is rounded by adding 2 and then shifting arithmetically right by 2.
- R8: A rounded value above 127 gives 127, and a rounded value below -128 gives -128.
- R9: A zero vector stays zero through every stage and gives a zero output, whatever the mode and direction bits are.
- R10: The mode and direction bits that apply to a vector are the ones sampled together with that vector. Values presented on neighbouring cycles have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input vector present |
| in_mode | input | 1 | Global direction inversion for this vector |
| in_dir | input | 8 | Per-iteration direction bits; bit i drives iteration i |
| in_x | input | 8 | X component, two's complement |
| in_y | input | 8 | Y component, two's complement |
| out_valid | output | 1 | Result present |
| out_x | output | 8 | Rotated and scaled X, rounded and saturated |
| out_y | output | 8 | Rotated and scaled Y, rounded and saturated |

## Verification
A wrong add or subtract choice in one stage, or a direction bit that is misrouted or lags by a cycle, changes the output of only the vector it touches. That error shows exactly fourteen cycles after the vector enters. A long burst of varied vectors, compared word by word against an independent shift-add model, therefore catches it. A valid flag that is dropped, doubled or not cleared shows up at once as a result that is missing, unexpected or late. Faults in rounding and clamping appear only near range limits or odd fractional bits, so those vectors are driven on purpose.

// File: rtl/cordic_rot_pipe.sv
module cordic_rot_pipe #(
  parameter int IN_W    = 8,
  parameter int DP_W    = 12,
  parameter int ITER    = 8,
  parameter int FRAC    = 2,
  parameter int SCALE_N = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   in_mode,
  input  logic [ITER-1:0]        in_dir,
  input  logic signed [IN_W-1:0] in_x,
  input  logic signed [IN_W-1:0] in_y,
  output logic                   out_valid,
  output logic signed [IN_W-1:0] out_x,
  output logic signed [IN_W-1:0] out_y
);
  localparam int DEPTH = ITER + SCALE_N;
  localparam int OMAX  = 2**(IN_W-1) - 1;
  localparam int OMIN  = -(2**(IN_W-1));
  localparam int HALF  = 2**(FRAC-1);

  typedef logic signed [DP_W-1:0] dp_t;
  typedef logic signed [DP_W:0]   wd_t;

  function automatic int scl_shift(input int j);
    case (j)
      0: return 2;
      1: return 3;
      2: return 4;
      3: return 6;
      4: return 9;
      default: return 11;
    endcase
  endfunction

  function automatic logic signed [IN_W-1:0] clamp(input wd_t v);
    if (v > wd_t'(OMAX)) return IN_W'(OMAX);
    if (v < wd_t'(OMIN)) return IN_W'(OMIN);
    return v[IN_W-1:0];
  endfunction

  dp_t             xs [DEPTH+1];
  dp_t             ys [DEPTH+1];
  logic            vs [DEPTH+1];
  logic            ms [ITER];
  logic [ITER-1:0] ds [ITER];

  assign xs[0] = dp_t'(in_x) <<< FRAC;
  assign ys[0] = dp_t'(in_y) <<< FRAC;
  assign vs[0] = in_valid;
  assign ms[0] = in_mode;
  assign ds[0] = in_dir;

  for (genvar k = 0; k < ITER; k++) begin : g_rot
    dp_t  xr, yr;
    logic vr;
    logic flip;
    dp_t  xq, yq;

    assign flip = ms[k] ^ ds[k][k];
    assign xq   = xs[k] >>> k;
    assign yq   = ys[k] >>> k;

    always_ff @(posedge clk) begin
      vr <= rst ? 1'b0 : vs[k];
      xr <= flip ? xs[k] - yq : xs[k] + yq;
      yr <= ~flip ? ys[k] - xq : ys[k] + xq;
    end

    assign xs[k+1] = xr;
    assign ys[k+1] = yr;
    assign vs[k+1] = vr;

    if (k < ITER-1) begin : g_ctl
      logic            mr;
      logic [ITER-1:0] dr;
      always_ff @(posedge clk) begin
        mr <= ms[k];
        dr <= ds[k];
      end
      assign ms[k+1] = mr;
      assign ds[k+1] = dr;
    end

    p_zero_stays_r9: assert property (@(posedge clk) disable iff (rst)
      (xs[k] == '0 && ys[k] == '0) |=> (xs[k+1] == '0 && ys[k+1] == '0));
  end

  for (genvar j = 0; j < SCALE_N; j++) begin : g_scl
    localparam int  SH  = scl_shift(j);
    localparam bit  SUB = (j < 4);
    localparam int  IX  = ITER + j;
    dp_t  xr, yr;
    logic vr;
    dp_t  xq, yq;

    assign xq = xs[IX] >>> SH;
    assign yq = ys[IX] >>> SH;

    always_ff @(posedge clk) begin
      vr <= rst ? 1'b0 : vs[IX];
      xr <= SUB ? xs[IX] - xq : xs[IX] + xq;
      yr <= SUB ? ys[IX] - yq : ys[IX] + yq;
    end

    assign xs[IX+1] = xr;
    assign ys[IX+1] = yr;
    assign vs[IX+1] = vr;

    p_sign_nonneg_r6: assert property (@(posedge clk) disable iff (rst)
      (xs[IX] >= 0) |=> (xs[IX+1] >= 0));
    p_sign_nonpos_r6: assert property (@(posedge clk) disable iff (rst)
      (ys[IX] <= 0) |=> (ys[IX+1] <= 0));
  end

  wd_t rx, ry;
  assign rx = (wd_t'(xs[DEPTH]) + wd_t'(HALF)) >>> FRAC;
  assign ry = (wd_t'(ys[DEPTH]) + wd_t'(HALF)) >>> FRAC;

  assign out_valid = vs[DEPTH];
  assign out_x     = clamp(rx);
  assign out_y     = clamp(ry);

  p_flush_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid);
  p_sat_hi_r8: assert property (@(posedge clk) disable iff (rst)
    (rx > wd_t'(OMAX)) |-> (out_x == IN_W'(OMAX)));
  p_sat_lo_r8: assert property (@(posedge clk) disable iff (rst)
    (ry < wd_t'(OMIN)) |-> (out_y == IN_W'(OMIN)));
endmodule

// File: tb/test_cordic_rot_pipe.sv
module test_cordic_rot_pipe;
  localparam int CLK_T = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_mode = 1'b0;
  logic [7:0] in_dir = '0;
  logic signed [7:0] in_x = '0;
  logic signed [7:0] in_y = '0;
  logic       out_valid;
  logic signed [7:0] out_x;
  logic signed [7:0] out_y;

  cordic_rot_pipe i_cordic_rot_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .in_dir(in_dir), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y)
  );

  always #(CLK_T/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int    ex_q[$];
  int    ey_q[$];
  int    at_q[$];
  string tg_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int w12(input int v);
    logic signed [11:0] t;
    t = v[11:0];
    return int'(t);
  endfunction

  function automatic int sat8(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  task automatic model(input int x, input int y, input bit mode,
                       input bit [7:0] dir, output int ox, output int oy);
    int a, b, na, nb;
    int sh[6] = '{2, 3, 4, 6, 9, 11};
    a = x * 4;
    b = y * 4;
    for (int i = 0; i < 8; i++) begin
      if ((mode ^ dir[i]) == 1'b0) begin
        na = a + (b >>> i);
        nb = b - (a >>> i);
      end else begin
        na = a - (b >>> i);
        nb = b + (a >>> i);
      end
      a = w12(na);
      b = w12(nb);
    end
    for (int j = 0; j < 6; j++) begin
      if (j < 4) begin
        a = w12(a - (a >>> sh[j]));
        b = w12(b - (b >>> sh[j]));
      end else begin
        a = w12(a + (a >>> sh[j]));
        b = w12(b + (b >>> sh[j]));
      end
    end
    ox = sat8((a + 2) >>> 2);
    oy = sat8((b + 2) >>> 2);
  endtask

  task automatic send(input int x, input int y, input bit mode,
                      input bit [7:0] dir, input string tag);
    int ox, oy;
    model(x, y, mode, dir, ox, oy);
    in_valid = 1'b1;
    in_x = 8'(x);
    in_y = 8'(y);
    in_mode = mode;
    in_dir = dir;
    ex_q.push_back(ox);
    ey_q.push_back(oy);
    at_q.push_back(cyc + 14);
    tg_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    in_mode = ~in_mode;
    in_dir = ~in_dir;
    in_x = ~in_x;
    in_y = ~in_y;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (ex_q.size() == 0) begin
        chk(1'b0, "R2", "unexpected out_valid", 1, 0);
      end else begin
        int ex, ey, at;
        string tg;
        ex = ex_q.pop_front();
        ey = ey_q.pop_front();
        at = at_q.pop_front();
        tg = tg_q.pop_front();
        chk(int'(out_x) == ex, tg, "out_x", int'(out_x), ex);
        chk(int'(out_y) == ey, tg, "out_y", int'(out_y), ey);
        chk(cyc == at, "R2", "arrival cycle", cyc, at);
      end
    end
  end

  initial begin
    #(CLK_T * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [15:0] lf = 16'hACE1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "idle out_valid", out_valid, 0);
    end

    send(0, 0, 1'b0, 8'h00, "R9");
    send(0, 0, 1'b1, 8'hA5, "R9");
    send(1, 0, 1'b0, 8'h00, "R5");
    send(-1, -1, 1'b1, 8'h3C, "R5");
    send(100, 0, 1'b0, 8'h00, "R6");
    send(0, -100, 1'b1, 8'hFF, "R6");
    send(-3, 5, 1'b0, 8'h5A, "R7");
    send(3, -5, 1'b1, 8'h96, "R7");
    send(120, 0, 1'b0, 8'h01, "R4");
    send(120, 0, 1'b0, 8'h80, "R4");
    send(120, 0, 1'b1, 8'h01, "R4");
    send(127, 127, 1'b0, 8'h00, "R8");
    send(-128, -128, 1'b0, 8'h00, "R8");
    send(-128, 127, 1'b1, 8'hF0, "R8");
    idle(1);
    send(-57, 33, 1'b0, 8'h11, "R3");
    idle(2);
    send(64, -64, 1'b1, 8'h22, "R3");
    idle(20);

    for (int i = 0; i < 200; i++) begin
      int x, y;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      x = int'($signed(lf[7:0]));
      y = int'($signed(lf[15:8]));
      send(x, y, lf[3], lf[11:4] ^ 8'(i), (i % 2) ? "R10" : "R2");
    end
    idle(20);
    chk(ex_q.size() == 0, "R2", "pending after burst", ex_q.size(), 0);

    send(50, 20, 1'b0, 8'h0F, "R1");
    send(-50, 20, 1'b1, 8'hF0, "R1");
    send(10, 90, 1'b0, 8'hAA, "R1");
    idle(2);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    ex_q.delete();
    ey_q.delete();
    at_q.delete();
    tg_q.delete();
    rst = 1'b0;
    chk(out_valid == 1'b0, "R1", "out_valid after mid reset", out_valid, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "flushed out_valid", out_valid, 0);
    end

    send(77, -12, 1'b1, 8'h5C, "R2");
    idle(20);
    chk(ex_q.size() == 0, "R2", "pending at end", ex_q.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule